// File: doc/BRIEF.md
# Post-Command Flash Settle Timer

After a serial flash controller finishes shifting out certain maintenance commands, the flash needs time before it can be addressed again. This block provides that pause. It receives a one-cycle completion pulse together with a code saying which command just went out. It also takes a 10-bit base delay, one scale-select bit for each of the five timed command kinds, and separate wait enables for program-erase resume and program-erase suspend. It then holds `busy_o` for the scaled number of SPI clock cycles and pulses `done_o` once the pause is over.

The scaled length is the base shifted left by 2 (×4) or by 7 (×128), giving a 17-bit cycle count, so no multiplier is needed. Some completions need no pause: an untimed command kind, a disabled resume/suspend wait, or a zero base. For these the block only pulses `done_o` on the next cycle. The controller around it waits for `done_o` before it issues further flash traffic.

Top module: `flash_cmd_settle_timer`

## Requirements
- R1: While `rst_n` is low, and directly after it is released, `busy_o` and `done_o` are 0. Asserting `rst_n` during a wait clears `busy_o` at once.
- R2: The command code on `cmd_kind_i` is 1 for high-performance-mode entry, 2 for release-from-power-down, 3 for deep power-down, 4 for program-erase resume and 5 for program-erase suspend. For codes 1 to 3, a scale bit of 0 gives a wait of `dly_base_i`×4 cycles.
- R3: `scale_sel_i` bit 0 belongs to code 1, bit 1 to code 2, bit 2 to code 3, bit 3 to code 4 and bit 4 to code 5. A set bit gives `dly_base_i`×128 cycles. Only the bit of the current code matters.
- R4: Code 4 waits only when `resume_wait_en_i` is 1, and code 5 waits only when `suspend_wait_en_i` is 1. When the enable is 0, the scale bit has no effect and no wait occurs.
- R5: Codes 0, 6 and 7 never cause a wait.
- R6: A base of 0 gives no wait for any code.
- R7: For an accepted pulse with a wait of N cycles, `busy_o` is high for exactly N cycles, starting in the cycle after the pulse. `done_o` is high for one cycle, in the cycle after `busy_o` falls. With no wait, `done_o` is high in the cycle after the pulse and `busy_o` stays low.
- R8: Base, scale and enable inputs are captured when the pulse is accepted. Changing them during a wait does not alter that wait.
- R9: A completion pulse that arrives while `busy_o` is high is ignored. It neither restarts nor extends the wait, and it produces no extra `done_o`.
- R10: `busy_o` and `done_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SPI clock; one wait cycle per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_done_i | input | 1 | One-cycle pulse: a command has been sent out |
| cmd_kind_i | input | 3 | Code of the completed command |
| dly_base_i | input | 10 | Base delay count |
| scale_sel_i | input | 5 | Per-code scale select, 1 = ×128, 0 = ×4 |
| resume_wait_en_i | input | 1 | Enables the wait after program-erase resume |
| suspend_wait_en_i | input | 1 | Enables the wait after program-erase suspend |
| busy_o | output | 1 | High while the pause is running |
| done_o | output | 1 | One-cycle pulse when the pause is over |

## Verification
The bench measures the exact number of busy cycles for every code under both scales. This would expose an off-by-one load, a wrong shift amount, or a scale bit wired to the wrong code. One wait exceeds 65535 cycles, so a counter truncated to 16 bits would end early. Disabled resume/suspend waits, untimed codes and a zero base must give an immediate done. A design that ignored the enables would stall, and one that decremented from zero would wrap into a huge wait. Directed cases change the inputs mid-wait, fire a second pulse while busy and reset mid-wait. They catch a design that reads live inputs, restarts on a new pulse, or holds busy through reset.

// File: rtl/settle_pkg.sv
package settle_pkg;
  // Number of command codes that carry their own scale bit
  localparam int unsigned N_TIMED = 5;
  // Code of the first timed command; timed codes are consecutive
  localparam logic [2:0] FIRST_TIMED_CODE = 3'd1;
  // Index of the gated kinds within the timed group
  localparam int unsigned IDX_RESUME  = 3;
  localparam int unsigned IDX_SUSPEND = 4;
endpackage

// File: rtl/settle_len_calc.sv
module settle_len_calc
  import settle_pkg::*;
#(
  parameter int unsigned BASE_W   = 10,
  parameter int unsigned SHIFT_LO = 2,
  parameter int unsigned SHIFT_HI = 7,
  parameter int unsigned KIND_W   = 3,
  parameter int unsigned LEN_W    = BASE_W + SHIFT_HI
) (
  input  logic [KIND_W-1:0]  kind_i,
  input  logic [BASE_W-1:0]  base_i,
  input  logic [N_TIMED-1:0] scale_i,
  input  logic               resume_en_i,
  input  logic               suspend_en_i,
  output logic [LEN_W-1:0]   len_o,
  output logic               need_wait_o
);
  localparam int unsigned PAD_W = LEN_W - BASE_W;

  logic [N_TIMED-1:0] kind_hit;
  logic [N_TIMED-1:0] kind_gate;
  logic [LEN_W-1:0]   base_ext;
  logic               long_scale;
  logic               timed;

  // One decode slice per timed command code
  for (genvar i = 0; i < N_TIMED; i++) begin : g_kind
    assign kind_hit[i] = (kind_i == KIND_W'(FIRST_TIMED_CODE + i));
    if (i == IDX_RESUME) begin : g_resume
      assign kind_gate[i] = resume_en_i;
    end else if (i == IDX_SUSPEND) begin : g_suspend
      assign kind_gate[i] = suspend_en_i;
    end else begin : g_always
      assign kind_gate[i] = 1'b1;
    end
  end

  always_comb begin
    base_ext    = {{PAD_W{1'b0}}, base_i};
    long_scale  = |(kind_hit & scale_i);
    timed       = |(kind_hit & kind_gate);
    len_o       = long_scale ? (base_ext << SHIFT_HI) : (base_ext << SHIFT_LO);
    need_wait_o = timed && (base_i != '0);
  end
endmodule

// File: rtl/settle_counter.sv
module settle_counter #(
  parameter int unsigned LEN_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             need_wait_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic             cnt_en;

  // Next-state logic
  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    cnt_en = 1'b0;
    if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q - 1'b1;
      end
    end else if (start_i) begin
      if (need_wait_i) begin
        busy_d = 1'b1;
        cnt_en = 1'b1;
        cnt_d  = len_i - 1'b1;
      end else begin
        done_d = 1'b1;
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  // Count register with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/flash_cmd_settle_timer.sv
module flash_cmd_settle_timer
  import settle_pkg::*;
#(
  parameter int unsigned BASE_W   = 10,
  parameter int unsigned SHIFT_LO = 2,
  parameter int unsigned SHIFT_HI = 7,
  parameter int unsigned KIND_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_done_i,
  input  logic [KIND_W-1:0]  cmd_kind_i,
  input  logic [BASE_W-1:0]  dly_base_i,
  input  logic [N_TIMED-1:0] scale_sel_i,
  input  logic               resume_wait_en_i,
  input  logic               suspend_wait_en_i,
  output logic               busy_o,
  output logic               done_o
);
  localparam int unsigned LEN_W = BASE_W + SHIFT_HI;

  logic [LEN_W-1:0] wait_len;
  logic             wait_needed;

  settle_len_calc #(
    .BASE_W  (BASE_W),
    .SHIFT_LO(SHIFT_LO),
    .SHIFT_HI(SHIFT_HI),
    .KIND_W  (KIND_W),
    .LEN_W   (LEN_W)
  ) u_len (
    .kind_i      (cmd_kind_i),
    .base_i      (dly_base_i),
    .scale_i     (scale_sel_i),
    .resume_en_i (resume_wait_en_i),
    .suspend_en_i(suspend_wait_en_i),
    .len_o       (wait_len),
    .need_wait_o (wait_needed)
  );

  settle_counter #(
    .LEN_W(LEN_W)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (cmd_done_i),
    .need_wait_i(wait_needed),
    .len_i      (wait_len),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );
endmodule

// File: rtl/settle_timer_chk.sv
module settle_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_done_i,
  input logic busy_o,
  input logic done_o
);
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o)); // R10

  AST_FALL_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o); // R7

  AST_IDLE_PULSE_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && cmd_done_i) |=> (busy_o || done_o)); // R7

  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(cmd_done_i) && !$past(busy_o))); // R9

  AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ($past(busy_o) || $past(cmd_done_i))); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !cmd_done_i) |=> !done_o); // R7
endmodule

bind flash_cmd_settle_timer settle_timer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_done_i(cmd_done_i),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/flash_cmd_settle_timer_bench.sv
module flash_cmd_settle_timer_bench;
  logic       clk;
  logic       rst_n;
  logic       cmd_done_i;
  logic [2:0] cmd_kind_i;
  logic [9:0] dly_base_i;
  logic [4:0] scale_sel_i;
  logic       resume_wait_en_i;
  logic       suspend_wait_en_i;
  logic       busy_o;
  logic       done_o;

  int n_chk;
  int n_fail;
  bit finished;

  flash_cmd_settle_timer u_flash_cmd_settle_timer (
    .clk              (clk),
    .rst_n            (rst_n),
    .cmd_done_i       (cmd_done_i),
    .cmd_kind_i       (cmd_kind_i),
    .dly_base_i       (dly_base_i),
    .scale_sel_i      (scale_sel_i),
    .resume_wait_en_i (resume_wait_en_i),
    .suspend_wait_en_i(suspend_wait_en_i),
    .busy_o           (busy_o),
    .done_o           (done_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [2:0]  kind;
    logic [9:0]  base;
    logic [4:0]  scale;
    logic        res_en;
    logic        sus_en;
    logic [16:0] exp_len;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 10'd3,    5'b00000, 1'b0, 1'b0, 17'd12},    // R2 code1 x4
    '{3'd1, 10'd3,    5'b00001, 1'b0, 1'b0, 17'd384},   // R3 bit0 x128
    '{3'd2, 10'd5,    5'b00010, 1'b0, 1'b0, 17'd640},   // R3 bit1
    '{3'd2, 10'd5,    5'b11101, 1'b1, 1'b1, 17'd20},    // R3 other bits ignored
    '{3'd3, 10'd7,    5'b00100, 1'b0, 1'b0, 17'd896},   // R3 bit2
    '{3'd3, 10'd1023, 5'b00000, 1'b0, 1'b0, 17'd4092},  // R2 max base x4
    '{3'd4, 10'd2,    5'b01000, 1'b1, 1'b0, 17'd256},   // R4 resume enabled
    '{3'd4, 10'd2,    5'b01000, 1'b0, 1'b1, 17'd0},     // R4 resume disabled
    '{3'd5, 10'd9,    5'b10000, 1'b0, 1'b1, 17'd1152},  // R4 suspend enabled
    '{3'd5, 10'd9,    5'b10000, 1'b1, 1'b0, 17'd0},     // R4 suspend disabled
    '{3'd0, 10'd50,   5'b11111, 1'b1, 1'b1, 17'd0},     // R5 code0
    '{3'd1, 10'd0,    5'b11111, 1'b1, 1'b1, 17'd0},     // R6 zero base
    '{3'd4, 10'd6,    5'b10111, 1'b1, 1'b1, 17'd24},    // R3 resume own bit clear
    '{3'd3, 10'd600,  5'b00100, 1'b0, 1'b0, 17'd76800}, // R3 beyond 16 bits
    '{3'd6, 10'd10,   5'b11111, 1'b1, 1'b1, 17'd0},     // R5 code6
    '{3'd5, 10'd1,    5'b00000, 1'b0, 1'b1, 17'd4}      // R2 suspend x4
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] k, input logic [9:0] b, input logic [4:0] s,
                       input logic re, input logic se);
    cmd_kind_i        = k;
    dly_base_i        = b;
    scale_sel_i       = s;
    resume_wait_en_i  = re;
    suspend_wait_en_i = se;
    cmd_done_i        = 1'b1;
    @(negedge clk);
    cmd_done_i        = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(10 * 190000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int cnt;
    n_chk = 0;
    n_fail = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    cmd_done_i = 1'b0;
    cmd_kind_i = '0;
    dly_base_i = '0;
    scale_sel_i = '0;
    resume_wait_en_i = 1'b0;
    suspend_wait_en_i = 1'b0;

    // R1: reset holds both outputs low, even with a pulse applied
    repeat (2) @(negedge clk);
    cmd_kind_i = 3'd1; dly_base_i = 10'd4; cmd_done_i = 1'b1;
    @(negedge clk);
    cmd_done_i = 1'b0;
    chk(!busy_o && !done_o, "R1 in reset", {busy_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o, "R1 after release", {busy_o, done_o}, 0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      drive(VECS[v].kind, VECS[v].base, VECS[v].scale, VECS[v].res_en, VECS[v].sus_en);
      cnt = 0;
      while (busy_o && cnt < 100000) begin
        chk(!done_o, "R10 done during busy", 1, 0);
        cnt++;
        @(negedge clk);
      end
      chk(cnt == int'(VECS[v].exp_len), $sformatf("R7 busy length vec %0d", v),
          cnt, int'(VECS[v].exp_len));
      chk(done_o == 1'b1, $sformatf("R7 done after wait vec %0d", v), done_o, 1);
      @(negedge clk);
      chk(!done_o && !busy_o, $sformatf("R7 done single vec %0d", v), {busy_o, done_o}, 0);
    end

    // R8: inputs changed mid-wait do not alter the wait (expect 4*4 = 16)
    drive(3'd1, 10'd4, 5'b00000, 1'b0, 1'b0);
    cnt = 0;
    while (busy_o && cnt < 100000) begin
      cnt++;
      if (cnt == 1) begin
        dly_base_i = 10'd1023;
        scale_sel_i = 5'b11111;
        cmd_kind_i = 3'd3;
      end
      @(negedge clk);
    end
    chk(cnt == 16, "R8 busy length after input change", cnt, 16);
    chk(done_o == 1'b1, "R8 done", done_o, 1);
    @(negedge clk);

    // R9: a pulse while busy is ignored (expect 2*4 = 8 and one done)
    drive(3'd1, 10'd2, 5'b00000, 1'b0, 1'b0);
    cnt = 0;
    while (busy_o && cnt < 100000) begin
      cnt++;
      if (cnt == 3) begin
        cmd_kind_i = 3'd3;
        dly_base_i = 10'd100;
        scale_sel_i = 5'b11111;
        cmd_done_i = 1'b1;
      end else begin
        cmd_done_i = 1'b0;
      end
      @(negedge clk);
    end
    cmd_done_i = 1'b0;
    chk(cnt == 8, "R9 busy length with extra pulse", cnt, 8);
    chk(done_o == 1'b1, "R9 done", done_o, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!busy_o && !done_o, "R9 no restart", {busy_o, done_o}, 0);
    end

    // R1: reset during a wait clears busy at once
    drive(3'd2, 10'd50, 5'b00010, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    chk(busy_o == 1'b1, "R1 busy before mid reset", busy_o, 1);
    rst_n = 1'b0;
    #1;
    chk(!busy_o && !done_o, "R1 mid-wait reset", {busy_o, done_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o, "R1 idle after reset", {busy_o, done_o}, 0);

    finish_run();
  end
endmodule